// File: doc/BRIEF.md
# Coefficient Soft-Transition Sequencer

This block owns the live biquad coefficient table. Each band holds five coefficients per channel, for a left and a right channel. It moves one band from its present coefficients to a new set in equal steps, so the filter response does not jump. The host first writes the new values into a separate staging bank, with one row of five coefficients per channel. It then presents a band number, a channel mode and the independent-channel flag, and pulses `start_wr`. On each later sample tick the sequencer moves every affected coefficient one step further along a straight line from its old value to its staged value. On the last step each coefficient lands exactly on its target.

The control path is a five-state machine:
- `S_IDLE`: waits for a start. `start_wr` moves it to `S_LOAD`.
- `S_LOAD`: latches the start and target of every lane. It then goes to `S_WAIT`.
- `S_WAIT`: holds until `sample_tick`, then goes to `S_STEP`.
- `S_STEP`: writes one interpolation step into the live table. It returns to `S_WAIT`, or goes to `S_DONE` after the last step.
- `S_DONE`: clears the start flag and returns to `S_IDLE`.

`start_bit` is the self-clearing view of the start request, and `busy` is the pollable status. Both are high from the accepted start until the transition ends. The filter datapath reads coefficients through the combinational `rd_*` port.

Top module: `coef_glide_seq`

## Requirements
- R1: After reset, `busy` and `start_bit` are 0 and every live coefficient of every band and channel reads 0.
- R2: A `start_wr` pulse sampled while idle makes `busy` and `start_bit` read 1 from the following cycle.
- R3: With STEPS = 2^STEP_LOG2 (default 8), after the k-th accepted sample tick an affected coefficient reads s + floor((t - s) * k / STEPS). Here s is its value at start and t is its target. The value appears one cycle after the tick is sampled.
- R4: After tick number STEPS every affected coefficient equals its target exactly. `busy` stays 1 in the cycle the final value appears and reads 0 together with `start_bit` one cycle later.
- R5: Only the band given by `band_sel` (captured at start) changes. All other bands keep their values.
- R6: Channel mode 1 updates the left set only (channel index 0) and mode 2 the right set only (channel index 1). The other channel keeps its values.
- R7: Channel mode 0 with `indep_lr` = 1 moves the left set toward left staging and the right set toward right staging in the same ticks.
- R8: Channel mode 0 with `indep_lr` = 0 moves both sets toward the left staging row. The right staging row is not used.
- R9: Channel mode 3 is reserved and behaves exactly as mode 0.
- R10: A `start_wr` pulse while a transition runs is ignored. The running band, channel choice and finishing time are unchanged, and the band it names is not touched.
- R11: Live coefficients change only in the cycle after a sampled `sample_tick`. Without ticks a running transition holds its last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_we | input | 1 | Staging write strobe |
| stg_ch | input | 1 | Staging channel, 0 = left, 1 = right |
| stg_idx | input | IDX_W | Staging coefficient index, 0 to NUM_COEF-1 |
| stg_data | input | COEF_W | Staging coefficient value, two's complement |
| band_sel | input | BAND_W | Band to transition, captured at start |
| ch_mode | input | 2 | Channel mode: 0 both, 1 left, 2 right, 3 as 0 |
| indep_lr | input | 1 | 1 = separate left and right staging rows in mode 0 |
| start_wr | input | 1 | Start request pulse (host writes the start bit) |
| sample_tick | input | 1 | One pulse per sample period, paces the steps |
| start_bit | output | 1 | Start flag, cleared by hardware at completion |
| busy | output | 1 | Transition-running status |
| rd_band | input | BAND_W | Live table read band |
| rd_ch | input | 1 | Live table read channel, 0 = left, 1 = right |
| rd_idx | input | IDX_W | Live table read coefficient index |
| rd_data | output | COEF_W | Live coefficient, combinational from the address |

## Verification
The status flags are due one cycle after the start pulse is sampled. Each coefficient step is due one cycle after its tick is sampled. The flags drop one cycle after the final step appears. The bench drives every stimulus at a falling edge and samples the flags at the next falling edge. It queues the expected coefficient values only after the edge that should have written them, and reads them back through the combinational port within the same low half-cycle. For the last step, `busy` is checked high when the final values are read and low exactly one falling edge later, so an early or late finish is caught.

// File: rtl/coef_glide_pkg.sv
`timescale 1ns/1ps
package coef_glide_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_WAIT,
        S_STEP,
        S_DONE
    } cg_state_t;

    typedef enum logic [1:0] {
        CM_BOTH  = 2'd0,
        CM_LEFT  = 2'd1,
        CM_RIGHT = 2'd2,
        CM_RSVD  = 2'd3
    } ch_mode_t;

    localparam int CH_L   = 0;
    localparam int CH_R   = 1;
    localparam int NUM_CH = 2;

endpackage

// File: rtl/cg_stage_regs.sv
`timescale 1ns/1ps
module cg_stage_regs
    import coef_glide_pkg::*;
#(
    parameter int COEF_W   = 24,
    parameter int NUM_COEF = 5,
    parameter int IDX_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     wr_ch,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [COEF_W-1:0] wr_data,
    output logic signed [COEF_W-1:0] stage_q [NUM_CH][NUM_COEF]
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int i = 0; i < NUM_COEF; i++) begin
                    stage_q[c][i] <= '0;
                end
            end
        end else if (we && (int'(wr_idx) < NUM_COEF)) begin
            stage_q[wr_ch][wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/cg_lerp_lane.sv
`timescale 1ns/1ps
module cg_lerp_lane #(
    parameter int COEF_W    = 24,
    parameter int STEP_LOG2 = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic signed [COEF_W-1:0] src_val,
    input  logic signed [COEF_W-1:0] tgt_val,
    input  logic [STEP_LOG2:0]       k,
    output logic signed [COEF_W-1:0] value
);

    localparam int                 KW    = STEP_LOG2 + 1;
    localparam int                 PW    = COEF_W + STEP_LOG2 + 3;
    localparam logic [KW-1:0]      STEPS = KW'(1 << STEP_LOG2);

    logic signed [COEF_W-1:0] s_q, t_q;
    logic signed [PW-1:0]     s_x, t_x, k_x, diff, prod, scaled, sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            t_q <= '0;
        end else if (load_en) begin
            s_q <= src_val;
            t_q <= tgt_val;
        end
    end

    always_comb begin
        s_x    = {{(PW-COEF_W){s_q[COEF_W-1]}}, s_q};
        t_x    = {{(PW-COEF_W){t_q[COEF_W-1]}}, t_q};
        k_x    = {{(PW-KW){1'b0}}, k};
        diff   = t_x - s_x;
        prod   = diff * k_x;
        scaled = prod >>> STEP_LOG2;
        sum    = s_x + scaled;
        value  = COEF_W'(sum);
    end

    // R4: the last step of the line is the target itself
    p_hits_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (k == STEPS) |-> (value == t_q));

    // R3: a lane sits on its start value before the first step
    p_starts_at_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (k == '0) |-> (value == s_q));

endmodule

// File: rtl/cg_ctrl.sv
`timescale 1ns/1ps
module cg_ctrl
    import coef_glide_pkg::*;
#(
    parameter int BAND_W    = 5,
    parameter int STEP_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_wr,
    input  logic                sample_tick,
    input  logic [BAND_W-1:0]   band_in,
    input  logic [1:0]          mode_in,
    input  logic                indep_in,
    output logic                busy,
    output logic                start_bit,
    output logic                load_en,
    output logic                step_en,
    output logic [STEP_LOG2:0]  k_cnt,
    output logic [BAND_W-1:0]   band_q,
    output logic                en_l,
    output logic                en_r,
    output logic                indep_q
);

    localparam int            KW    = STEP_LOG2 + 1;
    localparam logic [KW-1:0] STEPS = KW'(1 << STEP_LOG2);

    cg_state_t state_q, state_d;
    ch_mode_t  mode_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_wr)    state_d = S_LOAD;
            S_LOAD:                   state_d = S_WAIT;
            S_WAIT:  if (sample_tick) state_d = S_STEP;
            S_STEP:  state_d = (k_cnt == STEPS) ? S_DONE : S_WAIT;
            S_DONE:                   state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    // outputs decoded from the state and the captured mode
    always_comb begin
        busy    = (state_q != S_IDLE);
        load_en = (state_q == S_LOAD);
        step_en = (state_q == S_STEP);
        unique case (mode_q)
            CM_LEFT:  begin en_l = 1'b1; en_r = 1'b0; end
            CM_RIGHT: begin en_l = 1'b0; en_r = 1'b1; end
            CM_BOTH,
            CM_RSVD:  begin en_l = 1'b1; en_r = 1'b1; end
            default:  begin en_l = 1'b1; en_r = 1'b1; end
        endcase
    end

    // context captured at an accepted start, step counter, start flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_q    <= '0;
            mode_q    <= CM_BOTH;
            indep_q   <= 1'b0;
            k_cnt     <= '0;
            start_bit <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_wr) begin
                    band_q    <= band_in;
                    mode_q    <= ch_mode_t'(mode_in);
                    indep_q   <= indep_in;
                    start_bit <= 1'b1;
                end
                S_LOAD: k_cnt <= '0;
                S_WAIT: if (sample_tick) k_cnt <= k_cnt + 1'b1;
                S_STEP: ;
                S_DONE: start_bit <= 1'b0;
                default: ;
            endcase
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_wr) |=> (busy && start_bit));

    p_flag_matches_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_bit == busy);

    p_ignore_band_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start_wr) |=> $stable(band_q));

    p_ignore_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && state_q != S_DONE && start_wr) |=> $stable(mode_q));

    p_k_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        k_cnt <= STEPS);

    p_last_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP && k_cnt == STEPS) |=> (state_q == S_DONE));

    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> (!busy && !start_bit));

    p_step_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> $past(sample_tick));

    p_reserved_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CM_RSVD) |-> (en_l && en_r));

endmodule

// File: rtl/coef_glide_seq.sv
`timescale 1ns/1ps
module coef_glide_seq
    import coef_glide_pkg::*;
#(
    parameter int NUM_BANDS = 32,
    parameter int COEF_W    = 24,
    parameter int NUM_COEF  = 5,
    parameter int STEP_LOG2 = 3,
    localparam int BAND_W   = $clog2(NUM_BANDS),
    localparam int IDX_W    = $clog2(NUM_COEF)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stg_we,
    input  logic                     stg_ch,
    input  logic [IDX_W-1:0]         stg_idx,
    input  logic [COEF_W-1:0]        stg_data,
    input  logic [BAND_W-1:0]        band_sel,
    input  logic [1:0]               ch_mode,
    input  logic                     indep_lr,
    input  logic                     start_wr,
    input  logic                     sample_tick,
    output logic                     start_bit,
    output logic                     busy,
    input  logic [BAND_W-1:0]        rd_band,
    input  logic                     rd_ch,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [COEF_W-1:0]        rd_data
);

    logic                     load_en, step_en, en_l, en_r, indep_q;
    logic [STEP_LOG2:0]       k_cnt;
    logic [BAND_W-1:0]        band_q;
    logic [NUM_CH-1:0]        ch_en;

    logic signed [COEF_W-1:0] stage_q  [NUM_CH][NUM_COEF];
    logic signed [COEF_W-1:0] live_q   [NUM_BANDS][NUM_CH][NUM_COEF];
    logic signed [COEF_W-1:0] lane_src [NUM_CH][NUM_COEF];
    logic signed [COEF_W-1:0] lane_tgt [NUM_CH][NUM_COEF];
    logic signed [COEF_W-1:0] lane_val [NUM_CH][NUM_COEF];

    cg_stage_regs #(
        .COEF_W   (COEF_W),
        .NUM_COEF (NUM_COEF),
        .IDX_W    (IDX_W)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (stg_we),
        .wr_ch   (stg_ch),
        .wr_idx  (stg_idx),
        .wr_data (stg_data),
        .stage_q (stage_q)
    );

    cg_ctrl #(
        .BAND_W    (BAND_W),
        .STEP_LOG2 (STEP_LOG2)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start_wr),
        .sample_tick (sample_tick),
        .band_in     (band_sel),
        .mode_in     (ch_mode),
        .indep_in    (indep_lr),
        .busy        (busy),
        .start_bit   (start_bit),
        .load_en     (load_en),
        .step_en     (step_en),
        .k_cnt       (k_cnt),
        .band_q      (band_q),
        .en_l        (en_l),
        .en_r        (en_r),
        .indep_q     (indep_q)
    );

    assign ch_en = {en_r, en_l};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
            assign lane_src[c][i] = live_q[band_q][c][i];
            if (c == CH_R) begin : g_right
                // shared mode: the right set follows the left staging row
                assign lane_tgt[c][i] = indep_q ? stage_q[CH_R][i] : stage_q[CH_L][i];
            end else begin : g_left
                assign lane_tgt[c][i] = stage_q[CH_L][i];
            end
            cg_lerp_lane #(
                .COEF_W    (COEF_W),
                .STEP_LOG2 (STEP_LOG2)
            ) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .load_en (load_en),
                .src_val (lane_src[c][i]),
                .tgt_val (lane_tgt[c][i]),
                .k       (k_cnt),
                .value   (lane_val[c][i])
            );
        end
    end

    // live coefficient table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANDS; b++) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    for (int i = 0; i < NUM_COEF; i++) begin
                        live_q[b][c][i] <= '0;
                    end
                end
            end
        end else if (step_en) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int i = 0; i < NUM_COEF; i++) begin
                    if (ch_en[c]) live_q[band_q][c][i] <= lane_val[c][i];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if ((int'(rd_band) < NUM_BANDS) && (int'(rd_idx) < NUM_COEF)) begin
            rd_data = live_q[rd_band][rd_ch][rd_idx];
        end
    end

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> !step_en);

    p_some_channel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> (ch_en != '0));

endmodule

// File: tb/test_coef_glide_seq.sv
`timescale 1ns/100ps
module test_coef_glide_seq;

    localparam int NB    = 32;
    localparam int NC    = 5;
    localparam int STEPS = 8;

    logic        clk, rst_n;
    logic        stg_we, stg_ch;
    logic [2:0]  stg_idx;
    logic [23:0] stg_data;
    logic [4:0]  band_sel;
    logic [1:0]  ch_mode;
    logic        indep_lr, start_wr, sample_tick;
    logic        start_bit, busy;
    logic [4:0]  rd_band;
    logic        rd_ch;
    logic [2:0]  rd_idx;
    logic [23:0] rd_data;

    coef_glide_seq i_coef_glide_seq (
        .clk(clk), .rst_n(rst_n),
        .stg_we(stg_we), .stg_ch(stg_ch), .stg_idx(stg_idx), .stg_data(stg_data),
        .band_sel(band_sel), .ch_mode(ch_mode), .indep_lr(indep_lr),
        .start_wr(start_wr), .sample_tick(sample_tick),
        .start_bit(start_bit), .busy(busy),
        .rd_band(rd_band), .rd_ch(rd_ch), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    typedef struct {
        int                 band;
        int                 ch;
        int                 idx;
        logic signed [23:0] val;
        string              req;
    } exp_t;

    exp_t               exp_q[$];
    int                 pend = 0;
    int                 checks = 0;
    int                 errors = 0;
    bit                 finished = 0;
    logic signed [23:0] mdl [NB][2][NC];
    logic signed [23:0] sl [NC];
    logic signed [23:0] sr [NC];

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic signed [23:0] lerp(logic signed [23:0] s,
                                                logic signed [23:0] t, int k);
        longint d = longint'(t) - longint'(s);
        longint p = (d * k) >>> 3;
        return 24'(longint'(s) + p);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor: pops expected items and compares them with the read port
    initial begin
        exp_t it;
        forever begin
            wait (exp_q.size() > 0);
            it      = exp_q.pop_front();
            rd_band = it.band[4:0];
            rd_ch   = it.ch[0];
            rd_idx  = it.idx[2:0];
            #0.2;
            checks++;
            if (rd_data !== it.val) begin
                errors++;
                $display("FAIL %s band %0d ch %0d coef %0d: actual %h expected %h",
                         it.req, it.band, it.ch, it.idx, rd_data, it.val);
            end
            pend--;
        end
    end

    task automatic push(int b, int c, int i, logic signed [23:0] v, string req);
        exp_t it;
        it.band = b; it.ch = c; it.idx = i; it.val = v; it.req = req;
        exp_q.push_back(it);
        pend++;
    endtask

    task automatic push_band(int b, string req);
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < NC; i++)
                push(b, c, i, mdl[b][c][i], req);
    endtask

    task automatic flush();
        wait (pend == 0);
        @(negedge clk);
    endtask

    task automatic stage_write(int c, int i, logic signed [23:0] v);
        stg_we = 1'b1; stg_ch = c[0]; stg_idx = i[2:0]; stg_data = v;
        @(negedge clk);
        stg_we = 1'b0;
    endtask

    task automatic run_trans(int band, int mode, bit indep, int hold_at,
                             bit poke, int poke_band);
        logic signed [23:0] s [2][NC];
        logic signed [23:0] t [2][NC];
        bit en [2];
        for (int i = 0; i < NC; i++) begin
            stage_write(0, i, sl[i]);
            stage_write(1, i, sr[i]);
        end
        en[0] = (mode != 2);
        en[1] = (mode != 1);
        for (int i = 0; i < NC; i++) begin
            s[0][i] = mdl[band][0][i];
            s[1][i] = mdl[band][1][i];
            t[0][i] = sl[i];
            t[1][i] = indep ? sr[i] : sl[i];
        end
        band_sel = band[4:0]; ch_mode = mode[1:0]; indep_lr = indep;
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        chk(busy === 1'b1, "R2", "busy after start", busy, 1);
        chk(start_bit === 1'b1, "R2", "start_bit after start", start_bit, 1);
        @(negedge clk);
        for (int k = 1; k <= STEPS; k++) begin
            if (poke && k == 2) begin
                band_sel = poke_band[4:0]; ch_mode = 2'd2; indep_lr = 1'b0;
                start_wr = 1'b1;
                @(negedge clk);
                start_wr = 1'b0;
                band_sel = band[4:0];
            end
            sample_tick = 1'b1;
            @(negedge clk);
            sample_tick = 1'b0;
            @(negedge clk);
            for (int c = 0; c < 2; c++)
                for (int i = 0; i < NC; i++)
                    if (en[c]) mdl[band][c][i] = lerp(s[c][i], t[c][i], k);
            if (k == STEPS) begin
                chk(busy === 1'b1, "R4", "busy with final step", busy, 1);
                push_band(band, "R4");
                flush();
                chk(busy === 1'b0, "R4", "busy one cycle after final", busy, 0);
                chk(start_bit === 1'b0, "R4", "start_bit self-clear", start_bit, 0);
            end else begin
                push_band(band, "R3");
                flush();
            end
            if (k == hold_at) begin
                repeat (10) @(negedge clk);
                push_band(band, "R11");
                flush();
            end
        end
    endtask

    initial begin
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < 2; c++)
                for (int i = 0; i < NC; i++)
                    mdl[b][c][i] = '0;
        rst_n = 1'b0; stg_we = 0; stg_ch = 0; stg_idx = 0; stg_data = 0;
        band_sel = 0; ch_mode = 0; indep_lr = 0; start_wr = 0; sample_tick = 0;
        rd_band = 0; rd_ch = 0; rd_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(busy === 1'b0, "R1", "busy at reset", busy, 0);
        chk(start_bit === 1'b0, "R1", "start_bit at reset", start_bit, 0);
        for (int b = 0; b < NB; b++) push_band(b, "R1");
        flush();

        // R7: independent left/right targets, mode 0, band 3
        sl = '{24'sh123456, -24'sd2097152, 24'sh00FF01, 24'sh3FFFFF, -24'sd4194304};
        sr = '{-24'sd703710, 24'sh150000, 24'sh000007, -24'sd3, 24'sh2AAAAA};
        run_trans(3, 0, 1'b1, 3, 1'b0, 0);
        push_band(3, "R7");
        push_band(2, "R5");
        push_band(4, "R5");
        flush();

        // R6: left only, then right only, on the same band
        sl = '{-24'sd1048576, 24'sh010203, 24'sh7FFFF0, -24'sd5, 24'sh000011};
        sr = '{24'sh0F0F0F, 24'sh000000, -24'sd77, 24'sh600000, 24'sh000001};
        run_trans(3, 1, 1'b1, 0, 1'b0, 0);
        push_band(3, "R6");
        flush();
        sl = '{24'sh000100, 24'sh000200, 24'sh000300, 24'sh000400, 24'sh000500};
        run_trans(3, 2, 1'b1, 0, 1'b0, 0);
        push_band(3, "R6");
        flush();

        // R8: shared mode, right staging must not be used
        sl = '{24'sh2468AC, -24'sd123457, 24'sh000009, 24'sh400000, -24'sd8388608};
        sr = '{24'sh111111, 24'sh222222, 24'sh333333, 24'sh444444, 24'sh555555};
        run_trans(7, 0, 1'b0, 0, 1'b0, 0);
        push_band(7, "R8");
        flush();

        // R9: reserved mode acts as both channels
        sl = '{24'sh000FFF, -24'sd4095, 24'sh7FFFFF, -24'sd1, 24'sh0ABCDE};
        sr = '{-24'sd65536, 24'sh030303, 24'sh000000, 24'sh1FFFFF, -24'sd9};
        run_trans(9, 3, 1'b1, 0, 1'b0, 0);
        push_band(9, "R9");
        flush();

        // R10: a second start while running is ignored
        sl = '{24'sh050505, 24'sh060606, 24'sh070707, 24'sh080808, 24'sh090909};
        sr = '{-24'sd50, -24'sd60, -24'sd70, -24'sd80, -24'sd90};
        run_trans(12, 0, 1'b1, 0, 1'b1, 13);
        push_band(12, "R10");
        push_band(13, "R10");
        flush();
        chk(busy === 1'b0, "R10", "no restart after ignored start", busy, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R2 R4: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule